// File: doc/BRIEF.md
# Power-Line Burst-Gap Frame Receiver

This block rebuilds home-control frames from a receive line that falls once for every carrier burst seen on the mains. It does not look at the line on every half-cycle. It measures the time between accepted falling edges with a microsecond tick. It then turns each gap into a start-code step or a data bit, depending on the bit decoded just before. The frame opens with three bursts spaced one half-cycle apart. A trailing zero is assumed for the start code without being observed. Nine Manchester-style data bits follow, four for the house and five for the key, and each data bit covers two half-cycles.

When a frame completes, or reception fails, the block presents one record for a single cycle. The record holds a two-bit flag field, a house index and a key index. The two indices come from the received line codes through fixed inverse tables. A transmitter-busy input is captured when a frame opens, so software can tell that a frame was heard during its own transmission. A silence timer closes frames that stop part-way.

Top module: `x10_edge_rx`

## Requirements
- R1: After reset, `recValid` is 0 and `recFlags`, `recHouse` and `recKey` are all 0.
- R2: When idle, a falling edge of `rxPulseN` opens a frame and counts as the first start burst. `recFlags` bit 0 (local) of that frame's record equals `txBusy` in the cycle that edge is sampled.
- R3: The second and third start edges must each arrive strictly within HALF_US ± TOL_US ticks of the previous accepted edge, with `zcPhase` different from its value at that edge. Otherwise an error record is emitted at once.
- R4: After the third start edge, a zero is assumed for the fourth start half-cycle. The first data bit is then decoded as if the previous bit were 1.
- R5: With previous bit 1, a gap of 2 half-cycles decodes as 1 and a gap of 3 as 0. With previous bit 0, a gap of 1 decodes as 1 and a gap of 2 as 0. Each window is ±TOL_US exclusive. Any other gap emits an error record at once.
- R6: An edge that arrives fewer than MINGAP_US ticks after the last accepted edge is ignored. It neither restarts the silence timer nor changes the frame.
- R7: If SILENCE_US ticks pass with no accepted edge, reception ends. An error record is emitted only if at least two edges were accepted; after a single edge nothing is reported.
- R8: A frame is complete after 22 half-cycles (nine data bits). The first data bit becomes bit 8 of a 9-bit code, and the house index is the inverse house table applied to code[8:5]. House table, line code 0..15 to index: 12,4,2,10,14,6,0,8,13,5,3,11,15,7,1,9. The key index is the inverse key table applied to code[4:0]. Key table, line code 0..31 to index: 12,16,4,17,2,18,10,19,14,20,6,21,0,22,8,23,13,24,5,25,3,26,11,27,15,28,7,29,1,30,9,31.
- R9: `recFlags` bit 1 marks an invalid frame. Every error record reports house 0 and key 0, and its bit 0 still carries the captured local flag.
- R10: Each record is a one-cycle `recValid` pulse in the cycle after the deciding edge or timeout. All fields are valid with it and hold until the next record. The receiver is idle again in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| usTick | input | 1 | One-cycle strobe per microsecond |
| rxPulseN | input | 1 | Receive line, falls once per carrier burst |
| zcPhase | input | 1 | Mains zero-crossing phase level |
| txBusy | input | 1 | Local transmitter is sending |
| recValid | output | 1 | Record strobe |
| recFlags | output | 2 | Bit 0 local, bit 1 invalid |
| recHouse | output | 4 | House index |
| recKey | output | 5 | Key index |

## Verification
The assertions assume that all inputs are synchronous to `clk` and that TOL_US is well under half of HALF_US, so the three gap windows never overlap. They also assume SILENCE_US exceeds three half-cycles plus the tolerance. The stimulus changes `rxPulseN` and `zcPhase` only on the falling clock edge. It strobes `usTick` every other cycle and places bursts at whole multiples of a half-cycle, or at deliberate one-and-a-half-half-cycle faults. Every gap then lands either a tick or so from a window centre or far outside all windows, never near a window boundary.

// File: rtl/x10rx_pkg.sv
package x10rx_pkg;
  localparam int HCW        = 5;
  localparam int HOUSE_W    = 4;
  localparam int KEY_W      = 5;
  localparam int CODE_W     = HOUSE_W + KEY_W;

  typedef logic [HCW-1:0] half_t;
  localparam half_t H_ONE   = half_t'(1);
  localparam half_t H_TWO   = half_t'(2);
  localparam half_t H_START = half_t'(3);
  localparam half_t H_FRAME = half_t'(22);

  typedef enum logic {ST_IDLE, ST_RECV} rxState_e;

  typedef struct packed {
    logic restartTimer;
    logic shiftEn;
    logic shiftVal;
    logic emit;
    logic emitGood;
    logic localFlag;
  } rxCtrl_t;

  localparam logic [HOUSE_W-1:0] HOUSE_INV [16] = '{
    4'd12, 4'd4, 4'd2, 4'd10, 4'd14, 4'd6, 4'd0, 4'd8,
    4'd13, 4'd5, 4'd3, 4'd11, 4'd15, 4'd7, 4'd1, 4'd9};

  localparam logic [KEY_W-1:0] KEY_INV [32] = '{
    5'd12, 5'd16, 5'd4, 5'd17, 5'd2, 5'd18, 5'd10, 5'd19,
    5'd14, 5'd20, 5'd6, 5'd21, 5'd0, 5'd22, 5'd8, 5'd23,
    5'd13, 5'd24, 5'd5, 5'd25, 5'd3, 5'd26, 5'd11, 5'd27,
    5'd15, 5'd28, 5'd7, 5'd29, 5'd1, 5'd30, 5'd9, 5'd31};
endpackage

// File: rtl/rx_datapath.sv
module rx_datapath
  import x10rx_pkg::*;
#(
  parameter int HALF_US    = 8333,
  parameter int TOL_US     = 1388,
  parameter int MINGAP_US  = 1500,
  parameter int SILENCE_US = 50000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                usTick,
  input  logic                rxPulseN,
  input  rxCtrl_t             ctrl,
  output logic                fallEdge,
  output logic [2:0]          gapHit,
  output logic                tooSoon,
  output logic                silenceHit,
  output logic                recValid,
  output logic [1:0]          recFlags,
  output logic [HOUSE_W-1:0]  recHouse,
  output logic [KEY_W-1:0]    recKey
);
  localparam int CW = $clog2(SILENCE_US + 1);
  typedef logic [CW-1:0] cnt_t;
  localparam cnt_t SIL_C = cnt_t'(SILENCE_US);
  localparam cnt_t MIN_C = cnt_t'(MINGAP_US);

  cnt_t elapsed;
  logic rxPrev;
  logic [CODE_W-1:0] codeBits, codeNext;

  assign fallEdge   = rxPrev & ~rxPulseN;
  assign tooSoon    = elapsed < MIN_C;
  assign silenceHit = elapsed == SIL_C;

  for (genvar k = 1; k <= 3; k++) begin : g_win
    localparam cnt_t LO = cnt_t'(k * HALF_US - TOL_US);
    localparam cnt_t HI = cnt_t'(k * HALF_US + TOL_US);
    assign gapHit[k-1] = (elapsed > LO) && (elapsed < HI);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      elapsed <= '0;
      rxPrev  <= 1'b1;
    end else begin
      rxPrev <= rxPulseN;
      if (ctrl.restartTimer)
        elapsed <= '0;
      else if (usTick && elapsed < SIL_C)
        elapsed <= elapsed + cnt_t'(1);
    end
  end

  assign codeNext = ctrl.shiftEn ? {codeBits[CODE_W-2:0], ctrl.shiftVal} : codeBits;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      codeBits <= '0;
      recValid <= 1'b0;
      recFlags <= '0;
      recHouse <= '0;
      recKey   <= '0;
    end else begin
      codeBits <= codeNext;
      recValid <= ctrl.emit;
      if (ctrl.emit) begin
        recFlags <= {~ctrl.emitGood, ctrl.localFlag};
        recHouse <= ctrl.emitGood ? HOUSE_INV[codeNext[CODE_W-1:KEY_W]] : '0;
        recKey   <= ctrl.emitGood ? KEY_INV[codeNext[KEY_W-1:0]] : '0;
      end
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    recValid |=> !recValid); // R10
  AST_ERR_FIELDS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (recValid && recFlags[1]) |-> (recHouse == '0 && recKey == '0)); // R9
  AST_WINDOWS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gapHit) <= 1); // R5
endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import x10rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fallEdge,
  input  logic [2:0] gapHit,
  input  logic       tooSoon,
  input  logic       silenceHit,
  input  logic       zcPhase,
  input  logic       txBusy,
  output rxCtrl_t    ctrl
);
  rxState_e st, stN;
  half_t    halfCnt, halfN;
  logic     lastPhase, phaseN;
  logic     lastBit, bitN;
  logic     localReg, localN;
  logic     decodeOk, decodedBit;

  assign decodeOk   = lastBit ? (gapHit[1] | gapHit[2]) : (gapHit[0] | gapHit[1]);
  assign decodedBit = lastBit ? gapHit[1] : gapHit[0];

  always_comb begin
    stN    = st;
    halfN  = halfCnt;
    phaseN = lastPhase;
    bitN   = lastBit;
    localN = localReg;
    ctrl   = '0;
    ctrl.localFlag = localReg;
    unique case (st)
      ST_IDLE: begin
        if (fallEdge) begin
          ctrl.restartTimer = 1'b1;
          stN    = ST_RECV;
          halfN  = H_ONE;
          phaseN = zcPhase;
          localN = txBusy;
        end
      end
      ST_RECV: begin
        if (silenceHit) begin
          ctrl.emit = (halfCnt >= H_TWO);
          stN = ST_IDLE;
        end else if (fallEdge && !tooSoon) begin
          ctrl.restartTimer = 1'b1;
          if (halfCnt < H_START) begin
            if (gapHit[0] && (zcPhase != lastPhase)) begin
              phaseN = zcPhase;
              if (halfCnt == H_START - H_ONE) begin
                halfN = H_START + H_ONE;
                bitN  = 1'b1;
              end else begin
                halfN = halfCnt + H_ONE;
              end
            end else begin
              ctrl.emit = 1'b1;
              stN = ST_IDLE;
            end
          end else if (decodeOk) begin
            ctrl.shiftEn  = 1'b1;
            ctrl.shiftVal = decodedBit;
            bitN  = decodedBit;
            halfN = halfCnt + H_TWO;
            if (halfCnt + H_TWO == H_FRAME) begin
              ctrl.emit     = 1'b1;
              ctrl.emitGood = 1'b1;
              stN = ST_IDLE;
            end
          end else begin
            ctrl.emit = 1'b1;
            stN = ST_IDLE;
          end
        end
      end
      default: stN = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      halfCnt   <= '0;
      lastPhase <= 1'b0;
      lastBit   <= 1'b0;
      localReg  <= 1'b0;
    end else begin
      st        <= stN;
      halfCnt   <= halfN;
      lastPhase <= phaseN;
      lastBit   <= bitN;
      localReg  <= localN;
    end
  end

  AST_START_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && fallEdge) |=> (st == ST_RECV && halfCnt == H_ONE)); // R2
  AST_SOON_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RECV && fallEdge && tooSoon && !silenceHit) |=> (st == ST_RECV && $stable(halfCnt))); // R6
  AST_SILENCE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RECV && silenceHit) |=> st == ST_IDLE); // R7
  AST_HALF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_RECV |-> (halfCnt >= H_ONE && halfCnt < H_FRAME)); // R8
  AST_DATA_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RECV && halfCnt > H_START) |-> !halfCnt[0]); // R4
  AST_EMIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.emit |=> st == ST_IDLE); // R10
endmodule

// File: rtl/x10_edge_rx.sv
module x10_edge_rx
  import x10rx_pkg::*;
#(
  parameter int HALF_US    = 8333,
  parameter int TOL_US     = HALF_US / 6,
  parameter int MINGAP_US  = 1500,
  parameter int SILENCE_US = 50000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               usTick,
  input  logic               rxPulseN,
  input  logic               zcPhase,
  input  logic               txBusy,
  output logic               recValid,
  output logic [1:0]         recFlags,
  output logic [HOUSE_W-1:0] recHouse,
  output logic [KEY_W-1:0]   recKey
);
  rxCtrl_t    ctrl;
  logic       fallEdge, tooSoon, silenceHit;
  logic [2:0] gapHit;

  rx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .fallEdge(fallEdge), .gapHit(gapHit),
    .tooSoon(tooSoon), .silenceHit(silenceHit), .zcPhase(zcPhase),
    .txBusy(txBusy), .ctrl(ctrl)
  );

  rx_datapath #(
    .HALF_US(HALF_US), .TOL_US(TOL_US),
    .MINGAP_US(MINGAP_US), .SILENCE_US(SILENCE_US)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .usTick(usTick), .rxPulseN(rxPulseN),
    .ctrl(ctrl), .fallEdge(fallEdge), .gapHit(gapHit), .tooSoon(tooSoon),
    .silenceHit(silenceHit), .recValid(recValid), .recFlags(recFlags),
    .recHouse(recHouse), .recKey(recKey)
  );
endmodule

// File: tb/x10_edge_rx_test.sv
module x10_edge_rx_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 48;
  localparam int TOL = 8;
  localparam int MINGAP = 10;
  localparam int SIL = 300;
  localparam int HC = 2 * HALF;
  localparam int SETTLE = 2 * SIL + 100;

  logic clk = 0, rst_n = 0, usTick = 0, rxPulseN = 1, zcPhase = 0, txBusy = 0;
  logic recValid;
  logic [1:0] recFlags;
  logic [3:0] recHouse;
  logic [4:0] recKey;

  x10_edge_rx #(.HALF_US(HALF), .TOL_US(TOL), .MINGAP_US(MINGAP), .SILENCE_US(SIL)) uut (
    .clk(clk), .rst_n(rst_n), .usTick(usTick), .rxPulseN(rxPulseN), .zcPhase(zcPhase),
    .txBusy(txBusy), .recValid(recValid), .recFlags(recFlags), .recHouse(recHouse), .recKey(recKey));

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(negedge clk) usTick <= ~usTick;

  int invH[16] = '{12,4,2,10,14,6,0,8,13,5,3,11,15,7,1,9};
  int invK[32] = '{12,16,4,17,2,18,10,19,14,20,6,21,0,22,8,23,13,24,5,25,3,26,11,27,15,28,7,29,1,30,9,31};
  int fwdH[16];
  int fwdK[32];

  int nCmp = 0, nBad = 0;
  bit done = 0;
  logic [10:0] recQ[$];

  // behavioural reference model
  int mState, mHalf, mElapsed, mLast, mBits;
  bit mPrev, mPhase, mLocal, mValid;
  int mFlags, mHouse, mKey;

  function automatic bit near(int d, int k);
    return (d > k * HALF - TOL) && (d < k * HALF + TOL);
  endfunction

  always @(posedge clk) begin
    bit fall, restart, failed;
    int d, b;
    mValid = 0;
    if (!rst_n) begin
      mState = 0; mHalf = 0; mElapsed = 0; mLast = 0; mBits = 0;
      mPrev = 1; mPhase = 0; mLocal = 0; mFlags = 0; mHouse = 0; mKey = 0;
    end else begin
      fall = mPrev && !rxPulseN;
      d = mElapsed;
      restart = 0;
      failed = 0;
      if (mState == 1 && mElapsed == SIL) begin
        if (mHalf >= 2) begin mValid = 1; mFlags = 2 + mLocal; mHouse = 0; mKey = 0; end
        mState = 0;
      end else if (fall && mState == 0) begin
        mState = 1; mHalf = 1; mPhase = zcPhase; mLocal = txBusy; restart = 1;
      end else if (fall && d >= MINGAP) begin
        restart = 1;
        if (mHalf < 3) begin
          if (near(d, 1) && zcPhase != mPhase) begin
            mPhase = zcPhase;
            mHalf++;
            if (mHalf == 3) begin mHalf = 4; mLast = 1; end
          end else failed = 1;
        end else begin
          if (mLast == 1 && near(d, 2)) b = 1;
          else if (mLast == 1 && near(d, 3)) b = 0;
          else if (mLast == 0 && near(d, 1)) b = 1;
          else if (mLast == 0 && near(d, 2)) b = 0;
          else b = -1;
          if (b < 0) failed = 1;
          else begin
            mBits = ((mBits << 1) | b) & 511;
            mLast = b;
            mHalf += 2;
            if (mHalf == 22) begin
              mValid = 1; mFlags = mLocal;
              mHouse = invH[(mBits >> 5) & 15]; mKey = invK[mBits & 31];
              mState = 0;
            end
          end
        end
        if (failed) begin
          mValid = 1; mFlags = 2 + mLocal; mHouse = 0; mKey = 0; mState = 0;
        end
      end
      if (restart) mElapsed = 0;
      else if (usTick && mElapsed < SIL) mElapsed++;
      mPrev = rxPulseN;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      nCmp++;
      if (recValid !== mValid || recFlags !== 2'(mFlags) || recHouse !== 4'(mHouse) || recKey !== 5'(mKey)) begin
        nBad++;
        $display("FAIL R10 model compare at %0t: actual v=%b f=%0d h=%0d k=%0d expected v=%b f=%0d h=%0d k=%0d",
                 $time, recValid, recFlags, recHouse, recKey, mValid, mFlags, mHouse, mKey);
      end
      if (recValid) recQ.push_back({recFlags, recHouse, recKey});
    end
  end

  task automatic fire(bit ph);
    @(negedge clk); zcPhase = ph; rxPulseN = 0;
    @(negedge clk);
    @(negedge clk); rxPulseN = 1;
  endtask

  task automatic glitch();
    @(negedge clk); rxPulseN = 0;
    @(negedge clk); rxPulseN = 1;
  endtask

  task automatic runSeq(int t[$], bit p[$], bit busy, int glitchIdx);
    int extra = 0;
    for (int i = 0; i < t.size(); i++) begin
      if (i > 0) repeat (t[i] - t[i-1] - 3 - extra) @(negedge clk);
      extra = 0;
      if (i == 0) txBusy = busy;
      fire(p[i]);
      if (i == 0) txBusy = 0;
      if (i == glitchIdx) begin glitch(); extra = 2; end
    end
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic buildFrame(int h, int k, ref int t[$], ref bit p[$]);
    int code = (fwdH[h] << 5) | fwdK[k];
    t.delete(); p.delete();
    for (int i = 0; i < 3; i++) begin t.push_back(i * HC); p.push_back(i[0]); end
    for (int i = 0; i < 9; i++) begin
      int pos = 4 + 2 * i + (((code >> (8 - i)) & 1) ? 0 : 1);
      t.push_back(pos * HC); p.push_back(pos[0]);
    end
  endtask

  task automatic checkRecs(string tag, int n, logic [10:0] exp);
    nCmp++;
    if (recQ.size() != n) begin
      nBad++;
      $display("FAIL %s record count: actual %0d expected %0d", tag, recQ.size(), n);
    end else if (n > 0 && recQ[n-1] !== exp) begin
      nBad++;
      $display("FAIL %s record: actual f=%0d h=%0d k=%0d expected f=%0d h=%0d k=%0d", tag,
               recQ[n-1][10:9], recQ[n-1][8:5], recQ[n-1][4:0], exp[10:9], exp[8:5], exp[4:0]);
    end
    recQ.delete();
  endtask

  function automatic logic [10:0] rec(int f, int h, int k);
    return {2'(f), 4'(h), 5'(k)};
  endfunction

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    int t[$];
    bit p[$];
    for (int c = 0; c < 16; c++) fwdH[invH[c]] = c;
    for (int c = 0; c < 32; c++) fwdK[invK[c]] = c;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    nCmp++;
    if (recValid !== 0 || recFlags !== 0 || recHouse !== 0 || recKey !== 0) begin
      nBad++;
      $display("FAIL R1 reset: actual v=%b f=%0d h=%0d k=%0d expected all 0", recValid, recFlags, recHouse, recKey);
    end
    repeat (20) @(negedge clk);

    // R4 R5 R8: house 0 key 0 uses all four gap rules, first data bit 0 after inserted zero
    buildFrame(0, 0, t, p); runSeq(t, p, 0, -1);
    checkRecs("R4/R5/R8 frame h0 k0", 1, rec(0, 0, 0));

    // R2: local flag captured at the first edge only
    buildFrame(5, 20, t, p); runSeq(t, p, 1, -1);
    checkRecs("R2 local frame", 1, rec(1, 5, 20));

    // R6: glitch shortly after an accepted data edge is ignored
    buildFrame(15, 31, t, p); runSeq(t, p, 0, 5);
    checkRecs("R6 glitch ignored", 1, rec(0, 15, 31));

    // R3: second start edge late
    t = '{0, 144}; p = '{0, 1}; runSeq(t, p, 0, -1);
    checkRecs("R3 start timing", 1, rec(2, 0, 0));

    // R3: second start edge on same phase
    t = '{0, HC}; p = '{0, 0}; runSeq(t, p, 0, -1);
    checkRecs("R3 start phase", 1, rec(2, 0, 0));

    // R5: bad data gap
    buildFrame(3, 9, t, p);
    while (t.size() > 6) begin void'(t.pop_back()); void'(p.pop_back()); end
    t.push_back(t[5] + 144); p.push_back(1);
    runSeq(t, p, 0, -1);
    checkRecs("R5 bad gap", 1, rec(2, 0, 0));

    // R7: lone edge then silence yields nothing
    t = '{0}; p = '{0}; runSeq(t, p, 0, -1);
    checkRecs("R7 lone edge", 0, '0);

    // R7 R9: truncated frame closes by silence with error
    buildFrame(7, 12, t, p);
    while (t.size() > 8) begin void'(t.pop_back()); void'(p.pop_back()); end
    runSeq(t, p, 0, -1);
    checkRecs("R7/R9 truncated", 1, rec(2, 0, 0));

    // R9: error record keeps local flag
    t = '{0, HC}; p = '{0, 1}; runSeq(t, p, 1, -1);
    checkRecs("R9 local error", 1, rec(3, 0, 0));

    // R10 R8: two frames back to back
    buildFrame(10, 1, t, p);
    begin
      int t2[$];
      bit p2[$];
      buildFrame(12, 27, t2, p2);
      foreach (t2[i]) begin t.push_back(t2[i] + 22 * HC); p.push_back(p2[i]); end
    end
    runSeq(t, p, 0, -1);
    checkRecs("R10 back-to-back", 2, rec(0, 12, 27));

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule